// File: doc/BRIEF.md
# Circulating Loopback Receive FIFO

This block holds the receive side of a small split FIFO used while a network controller runs a loopback self-test. Each byte from the deserializer is stored at a write location that steps through eight entries and wraps around, so a long frame keeps overwriting older bytes. When the frame ends, the block stores a three-byte trailer built from an 11-bit receive byte count. The trailer is the low count byte, followed by the high count byte repeated once.

The host reads the eight locations through a read strobe. Reads start at location zero after a reset. For a frame of 8N+5 bytes, one sweep returns the last five payload bytes and then the trailer. Those five bytes are the four checksum bytes plus the byte before them, when a checksum is appended.

A synchronous reset clears the storage and realigns both pointers. It must be applied between frames, because after a frame ends the block ignores further input until it is reset.

Top module: `lbrx_fifo`

## Requirements
- R1: After `srst` is high for a clock edge, all eight locations read as 0x00, the read location is 0, the write location is 0 and the byte count is 0.
- R2: Each accepted `wr_en` stores `wr_data` at the current write location, and the write location then advances by one. The first byte of a frame lands in location 0.
- R3: The write location steps from 7 back to 0, and the new byte overwrites the one held there.
- R4: On an accepted `eof`, three bytes are stored in the three locations that follow the last payload byte. In order they are: the count bits 7:0, then count bits 10:8 zero-extended to eight bits, then count bits 10:8 again.
- R5: Trailer bytes that run past location 7 continue at location 0.
- R6: When `wr_en` and `eof` are high in the same cycle, the byte is stored first and is included in the count. The trailer occupies the three locations after that byte.
- R7: The byte count is 11 bits wide and increments once per accepted byte, rolling over from 2047 to 0. A 2047-byte frame gives the trailer 0xFF,0x07,0x07. A 2053-byte frame gives 0x05,0x00,0x00.
- R8: Once a frame has ended, `wr_en` and `eof` have no effect on storage, count or write location until the next `srst`.
- R9: `rd_data` shows the location at the read pointer. Each `rd_en` advances the read pointer by one, wrapping from 7 to 0. Reads never change stored bytes, and they are independent of writes.
- R10: After a frame of 8N+5 bytes and its `eof`, reads starting at location 0 return bytes 8N+1 to 8N+5, then the low count byte, then the high count byte twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high; clears storage, pointers and count |
| wr_en | input | 1 | Received byte strobe |
| wr_data | input | 8 | Received byte |
| eof | input | 1 | End-of-frame strobe; triggers the count trailer |
| rd_en | input | 1 | Host read strobe; advances the read pointer |
| rd_data | output | 8 | Byte at the current read location |

## Verification
Two functions can fall in the same cycle: storing the final payload byte and storing the trailer. Both happen when the last `wr_en` coincides with `eof`. The bench provokes this by raising both strobes together on a four-byte frame. It then sweeps all eight locations and expects the byte in location 3, a count of four in location 4, and zeros in the high-count locations. A second overlap, host reads running while bytes are still arriving, is driven by reading mid-frame and confirming that stored data and write order are unchanged.

// File: rtl/lbrx_pkg.sv
package lbrx_pkg;
    // number of count bytes appended after the payload
    localparam int TRAIL_LEN = 3;

    typedef enum logic {
        FR_OPEN   = 1'b0,
        FR_CLOSED = 1'b1
    } frame_st_e;
endpackage

// File: rtl/lbrx_bytecnt.sv
module lbrx_bytecnt #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             srst,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (inc) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/lbrx_wrctl.sv
module lbrx_wrctl
    import lbrx_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 11,
    parameter int NLANE  = 1 + TRAIL_LEN
) (
    input  logic                         clk,
    input  logic                         srst,
    input  logic                         wr_en,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         eof,
    input  logic [CNT_W-1:0]             cnt_q,
    output logic                         accept,
    output logic [NLANE-1:0]             lane_en,
    output logic [NLANE-1:0][$clog2(DEPTH)-1:0] lane_idx,
    output logic [NLANE-1:0][DATA_W-1:0] lane_dat,
    output logic [$clog2(DEPTH)-1:0]     wp,
    output logic                         closed
);
    localparam int PTR_W = $clog2(DEPTH);

    typedef struct packed {
        frame_st_e        fr;
        logic [PTR_W-1:0] wp;
    } st_t;

    st_t st_d, st_q;

    logic             fin;
    logic [CNT_W-1:0] cnt_inc;
    logic [PTR_W-1:0] base;
    logic [DATA_W-1:0] cnt_lo, cnt_hi;

    always_comb begin
        st_d     = st_q;
        accept   = wr_en && (st_q.fr == FR_OPEN);
        fin      = eof && (st_q.fr == FR_OPEN);
        // count as it stands after a byte in this same cycle
        cnt_inc  = cnt_q + CNT_W'(accept);
        cnt_lo   = DATA_W'(cnt_inc);
        cnt_hi   = DATA_W'(cnt_inc >> DATA_W);
        base     = st_q.wp + PTR_W'(accept);

        lane_en  = '0;
        lane_idx = '0;
        lane_dat = '0;

        lane_en[0]  = accept;
        lane_idx[0] = st_q.wp;
        lane_dat[0] = wr_data;

        for (int k = 0; k < TRAIL_LEN; k++) begin
            lane_en[k+1]  = fin;
            lane_idx[k+1] = base + PTR_W'(k);
            lane_dat[k+1] = (k == 0) ? cnt_lo : cnt_hi;
        end

        st_d.wp = fin ? (base + PTR_W'(TRAIL_LEN)) : base;
        if (fin) begin
            st_d.fr = FR_CLOSED;
        end
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            st_q <= '{fr: FR_OPEN, wp: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign wp     = st_q.wp;
    assign closed = (st_q.fr == FR_CLOSED);
endmodule

// File: rtl/lbrx_store.sv
module lbrx_store #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    parameter int NLANE  = 4
) (
    input  logic                         clk,
    input  logic                         srst,
    input  logic [NLANE-1:0]             lane_en,
    input  logic [NLANE-1:0][$clog2(DEPTH)-1:0] lane_idx,
    input  logic [NLANE-1:0][DATA_W-1:0] lane_dat,
    input  logic                         rd_en,
    output logic [DATA_W-1:0]            rd_data,
    output logic [$clog2(DEPTH)-1:0]     rp
);
    localparam int PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             rp;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // lanes target distinct locations since DEPTH >= NLANE
        for (int k = 0; k < NLANE; k++) begin
            if (lane_en[k]) begin
                st_d.mem[lane_idx[k]] = lane_dat[k];
            end
        end
        if (rd_en) begin
            st_d.rp = st_q.rp + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.mem[st_q.rp];
    assign rp      = st_q.rp;
endmodule

// File: rtl/lbrx_fifo.sv
module lbrx_fifo
    import lbrx_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 11
) (
    input  logic              clk,
    input  logic              srst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              eof,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);
    // DEPTH must be a power of two no smaller than the lane count
    localparam int PTR_W = $clog2(DEPTH);
    localparam int NLANE = 1 + TRAIL_LEN;

    logic                         accept;
    logic [CNT_W-1:0]             byte_cnt;
    logic [NLANE-1:0]             lane_en;
    logic [NLANE-1:0][PTR_W-1:0]  lane_idx;
    logic [NLANE-1:0][DATA_W-1:0] lane_dat;
    logic [PTR_W-1:0]             wr_ptr;
    logic [PTR_W-1:0]             rd_ptr;
    logic                         frame_closed;

    lbrx_bytecnt #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .srst (srst),
        .inc  (accept),
        .cnt  (byte_cnt)
    );

    lbrx_wrctl #(
        .DEPTH (DEPTH),
        .DATA_W(DATA_W),
        .CNT_W (CNT_W),
        .NLANE (NLANE)
    ) u_wrctl (
        .clk      (clk),
        .srst     (srst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .eof      (eof),
        .cnt_q    (byte_cnt),
        .accept   (accept),
        .lane_en  (lane_en),
        .lane_idx (lane_idx),
        .lane_dat (lane_dat),
        .wp       (wr_ptr),
        .closed   (frame_closed)
    );

    lbrx_store #(
        .DEPTH (DEPTH),
        .DATA_W(DATA_W),
        .NLANE (NLANE)
    ) u_store (
        .clk      (clk),
        .srst     (srst),
        .lane_en  (lane_en),
        .lane_idx (lane_idx),
        .lane_dat (lane_dat),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rp       (rd_ptr)
    );
endmodule

// File: rtl/lbrx_fifo_chk.sv
module lbrx_fifo_chk #(
    parameter int PTR_W  = 3,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 11
) (
    input logic              clk,
    input logic              srst,
    input logic              wr_en,
    input logic              eof,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic [PTR_W-1:0]  wp,
    input logic [PTR_W-1:0]  rp,
    input logic [CNT_W-1:0]  cnt,
    input logic              closed
);
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (srst)
        $fell(srst) |-> (rd_data == '0 && wp == '0 && rp == '0 && cnt == '0 && !closed)); // R1

    AST_WR_STEP: assert property (@(posedge clk) disable iff (srst)
        (wr_en && !eof && !closed) |=> (wp == PTR_W'($past(wp) + PTR_W'(1)))); // R2

    AST_TRAILER_ADV: assert property (@(posedge clk) disable iff (srst)
        (eof && !closed) |=> (closed && wp == PTR_W'($past(wp) + PTR_W'($past(wr_en)) + PTR_W'(3)))); // R6

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (srst)
        (wr_en && !closed) |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1)))); // R7

    AST_CLOSED_HOLD: assert property (@(posedge clk) disable iff (srst)
        closed |=> (closed && $stable(cnt) && $stable(wp))); // R8

    AST_RD_STEP: assert property (@(posedge clk) disable iff (srst)
        rd_en |=> (rp == PTR_W'($past(rp) + PTR_W'(1)))); // R9
endmodule

bind lbrx_fifo lbrx_fifo_chk #(
    .PTR_W (PTR_W),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk    (clk),
    .srst   (srst),
    .wr_en  (wr_en),
    .eof    (eof),
    .rd_en  (rd_en),
    .rd_data(rd_data),
    .wp     (wr_ptr),
    .rp     (rd_ptr),
    .cnt    (byte_cnt),
    .closed (frame_closed)
);

// File: tb/lbrx_fifo_bench.sv
`timescale 1ns/1ps
module lbrx_fifo_bench;
    logic       clk = 1'b0;
    logic       srst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       eof = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    lbrx_fifo u_lbrx_fifo (
        .clk    (clk),
        .srst   (srst),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .eof    (eof),
        .rd_en  (rd_en),
        .rd_data(rd_data)
    );

    // reference model built from the requirements
    logic [7:0] m_mem [8];
    int m_wp, m_rp, m_cnt;
    bit m_closed;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    task automatic m_clear();
        for (int i = 0; i < 8; i++) m_mem[i] = 8'h00;
        m_wp = 0; m_rp = 0; m_cnt = 0; m_closed = 1'b0;
    endtask

    task automatic m_byte(input logic [7:0] d);
        if (!m_closed) begin
            m_mem[m_wp] = d;
            m_wp  = (m_wp + 1) % 8;
            m_cnt = (m_cnt + 1) % 2048;
        end
    endtask

    task automatic m_eof();
        if (!m_closed) begin
            m_mem[m_wp]           = 8'(m_cnt & 255);
            m_mem[(m_wp + 1) % 8] = 8'(m_cnt >> 8);
            m_mem[(m_wp + 2) % 8] = 8'(m_cnt >> 8);
            m_wp = (m_wp + 3) % 8;
            m_closed = 1'b1;
        end
    endtask

    task automatic do_srst();
        srst = 1'b1;
        @(posedge clk); #2;
        srst = 1'b0;
        m_clear();
    endtask

    task automatic push_byte(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(posedge clk); #2;
        wr_en = 1'b0;
        m_byte(d);
    endtask

    task automatic push_eof();
        eof = 1'b1;
        @(posedge clk); #2;
        eof = 1'b0;
        m_eof();
    endtask

    task automatic push_last(input logic [7:0] d);
        wr_en = 1'b1; eof = 1'b1; wr_data = d;
        @(posedge clk); #2;
        wr_en = 1'b0; eof = 1'b0;
        m_byte(d);
        m_eof();
    endtask

    task automatic read_n(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(m_mem[m_rp]);
            tag_q.push_back(tag);
            m_rp = (m_rp + 1) % 8;
            rd_en = 1'b1;
            @(posedge clk); #2;
            rd_en = 1'b0;
        end
    endtask

    // monitor: compare each read against the scoreboard
    always @(negedge clk) begin
        if (rd_en && !srst) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read: rd_data=%02h expected none", rd_data);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL %s: rd_data=%02h expected %02h", t, rd_data, e);
                end
            end
        end
    end

    task automatic finish_sim();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: cycles=150000 expected completion");
        finish_sim();
    end

    initial begin
        m_clear();
        repeat (2) @(posedge clk);
        #2 srst = 1'b0;

        // R1 reset contents, R9 read wrap over sixteen reads
        read_n(8, "R1");
        read_n(8, "R9");

        // R2 R4 short frame
        do_srst();
        push_byte(8'hA1); push_byte(8'hB2); push_byte(8'hC3);
        push_eof();
        read_n(8, "R4");

        // R3 R10 13-byte frame (8N+5, N=1)
        do_srst();
        for (int i = 1; i <= 13; i++) push_byte(8'(8'h10 + i));
        push_eof();
        read_n(8, "R10");

        // R5 trailer wraps past location 7
        do_srst();
        for (int i = 0; i < 6; i++) push_byte(8'(8'h40 + i));
        push_eof();
        read_n(8, "R5");

        // R6 final byte and eof together
        do_srst();
        push_byte(8'h01); push_byte(8'h02); push_byte(8'h03);
        push_last(8'h04);
        read_n(8, "R6");

        // R8 input after frame end is ignored
        do_srst();
        push_byte(8'h77); push_byte(8'h88);
        push_eof();
        for (int i = 0; i < 5; i++) push_byte(8'hEE);
        push_eof();
        push_last(8'hDD);
        read_n(8, "R8");

        // R9 reads interleaved with writes leave data intact
        do_srst();
        push_byte(8'h5A); push_byte(8'h5B); push_byte(8'h5C);
        read_n(2, "R9");
        push_byte(8'h5D); push_byte(8'h5E);
        push_eof();
        read_n(10, "R9");

        // R7 count with upper bits set: 2047 bytes
        do_srst();
        for (int i = 0; i < 2047; i++) push_byte(8'(i * 3));
        push_eof();
        read_n(8, "R7");

        // R7 count rollover: 2053 bytes
        do_srst();
        for (int i = 0; i < 2053; i++) push_byte(8'(i + 9));
        push_eof();
        read_n(8, "R7");

        @(posedge clk); #2;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: pending=%0d expected 0", exp_q.size());
        end
        finish_sim();
    end
endmodule